// File: doc/BRIEF.md
# Two-Bank Hitless Lookup Table

This block holds a small exact-match table of key/result entries in two banks. At any moment one bank is live and answers every lookup; the other is the staging bank, and only it can be written. Lookups are answered one cycle after they are issued. A commit request flips which bank is live in a single register update, so every lookup is served wholly by the old table or wholly by the new one and never by a blend of the two.

After a commit, the bank that was live becomes a retired bank. It stays frozen, and writes to it are refused, until software acknowledges that the cutover is good. Software makes that judgement from per-bank hit and miss counters. Each bank records the table version that was current when it went live, and every lookup response carries the version that served it. This lets counts and responses be matched to a specific cutover. A second commit issued before the acknowledgement is refused and flagged.

Top module: `shb_table`

## Requirements
- R1: After reset, bank 0 is live, the version is 0, every lookup misses, no retirement is pending, busy and the write error flag are 0, and every counter and recorded bank version is 0.
- R2: A lookup presented with `lkp_req` produces `lkp_valid`=1 on the next cycle. `lkp_hit`=1 means a valid entry in the live bank has an equal key, and `lkp_res` then carries that entry's result. When several valid entries hold the same key, the lowest slot index wins. On a miss, `lkp_res` is 0.
- R3: When no retirement is pending, a write stores key, result and valid bit into the addressed slot of the staging bank only. Lookups made before the next commit are unaffected by the write.
- R4: A commit made while no retirement is pending flips `active_bank`, increments `cur_ver` (wrapping modulo 2^VER_W) and sets `retire_pending`, all visible on the next cycle. A lookup issued in the same cycle as the commit is served by the old bank and tagged with the old version.
- R5: A write made while `retire_pending`=1 is refused: `upd_err` is 1 on the next cycle and no bank changes. In every other cycle, `upd_err` is 0.
- R6: A commit made while `retire_pending`=1 is refused. It sets `busy` and leaves the live bank and the version unchanged.
- R7: `retire_ack` clears `retire_pending` and `busy`; `busy` is cleared even when a refused commit arrives in the same cycle. The retired bank then becomes the writable staging bank and keeps its old contents. An acknowledgement with nothing pending has no effect.
- R8: Each bank keeps a hit counter and a miss counter of the lookups it served. These counters saturate at all ones and are cleared when the bank goes live. At that moment the bank's recorded version is set to the new version. `lkp_ver` reports the version that served each lookup. Bank b occupies bits [b*CNT_W +: CNT_W] of the count ports and [b*VER_W +: VER_W] of `bank_ver`.
- R9: Writing a slot with `upd_vld`=0 removes that entry, so its key no longer hits once that bank is live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_req | input | 1 | Lookup request |
| lkp_key | input | KEY_W | Lookup key |
| upd_we | input | 1 | Write to the staging bank |
| upd_idx | input | $clog2(DEPTH) | Slot to write |
| upd_key | input | KEY_W | Key to store |
| upd_res | input | RES_W | Result to store |
| upd_vld | input | 1 | Valid bit to store (0 removes the entry) |
| commit_req | input | 1 | Request to flip the live bank |
| retire_ack | input | 1 | Software confirms the cutover |
| lkp_valid | output | 1 | Lookup response valid |
| lkp_hit | output | 1 | Lookup matched |
| lkp_res | output | RES_W | Result of the matching entry |
| lkp_ver | output | VER_W | Version that served the lookup |
| active_bank | output | 1 | Index of the live bank |
| cur_ver | output | VER_W | Current table version |
| retire_pending | output | 1 | Retired bank awaits acknowledgement |
| busy | output | 1 | A commit was refused |
| upd_err | output | 1 | A write was refused |
| hit_count | output | 2*CNT_W | Per-bank hit counters |
| miss_count | output | 2*CNT_W | Per-bank miss counters |
| bank_ver | output | 2*VER_W | Version recorded when each bank went live |

## Verification
The bench builds the block with 4-bit keys, 8-bit results, four slots per bank, 4-bit counters and a 3-bit version. With 4-bit keys, every lookup sweep covers the whole key space against a model computed in the bench. With 4-bit counters, saturation is reached after fifteen lookups. With a 3-bit version, ten commit/acknowledge rounds drive the version past its wrap. These settings also reach the commit-cycle lookup, the duplicate-key priority, and the refused-write and refused-commit paths within a few hundred cycles.

// File: rtl/shb_pkg.sv
package shb_pkg;
    localparam int NUM_BANKS = 2;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;
endpackage

// File: rtl/shb_bank.sv
module shb_bank #(
    parameter int KEY_W = 32,
    parameter int RES_W = 16,
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [KEY_W-1:0] wkey,
    input  logic [RES_W-1:0] wres,
    input  logic             wvld,
    input  logic [KEY_W-1:0] qkey,
    output logic             qhit,
    output logic [RES_W-1:0] qres
);
    logic [KEY_W-1:0] key_d [DEPTH];
    logic [KEY_W-1:0] key_q [DEPTH];
    logic [RES_W-1:0] res_d [DEPTH];
    logic [RES_W-1:0] res_q [DEPTH];
    logic [DEPTH-1:0] vld_d, vld_q;
    logic [DEPTH-1:0] match;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            key_d[i] = key_q[i];
            res_d[i] = res_q[i];
        end
        vld_d = vld_q;
        if (we) begin
            key_d[widx] = wkey;
            res_d[widx] = wres;
            vld_d[widx] = wvld;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                key_q[i] <= '0;
                res_q[i] <= '0;
            end
        end else begin
            vld_q <= vld_d;
            for (int i = 0; i < DEPTH; i++) begin
                key_q[i] <= key_d[i];
                res_q[i] <= res_d[i];
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (key_q[g] == qkey);
    end

    // lowest slot wins: scan from the top so the lowest match is written last
    always_comb begin
        qres = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match[i]) qres = res_q[i];
        end
    end
    assign qhit = |match;

    assert_write_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (vld_q[$past(widx)] == $past(wvld)));
endmodule

// File: rtl/shb_ctrl.sv
module shb_ctrl #(
    parameter int VER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit_req,
    input  logic             retire_ack,
    input  logic             upd_we,
    output logic             active,
    output logic [VER_W-1:0] version,
    output logic             pending,
    output logic             busy,
    output logic             upd_err,
    output logic             accept
);
    typedef struct packed {
        logic             active;
        logic [VER_W-1:0] version;
        logic             pending;
        logic             busy;
        logic             err;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  refuse;

    always_comb begin
        st_d   = st_q;
        accept = commit_req && !st_q.pending;
        refuse = commit_req && st_q.pending;
        st_d.err = upd_we && st_q.pending;
        if (accept) begin
            st_d.active  = ~st_q.active;
            st_d.version = st_q.version + 1'b1;
            st_d.pending = 1'b1;
        end
        if (retire_ack && st_q.pending) st_d.pending = 1'b0;
        if (retire_ack)  st_d.busy = 1'b0;
        else if (refuse) st_d.busy = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active  = st_q.active;
    assign version = st_q.version;
    assign pending = st_q.pending;
    assign busy    = st_q.busy;
    assign upd_err = st_q.err;

    assert_commit_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !pending) |=> (active != $past(active)) && pending);
    assert_retired_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !retire_ack) |=> pending);
    assert_busy_needs_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> pending);
endmodule

// File: rtl/shb_table.sv
module shb_table
    import shb_pkg::*;
#(
    parameter int KEY_W = 32,
    parameter int RES_W = 16,
    parameter int DEPTH = 16,
    parameter int CNT_W = 32,
    parameter int VER_W = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lkp_req,
    input  logic [KEY_W-1:0]           lkp_key,
    input  logic                       upd_we,
    input  logic [IDX_W-1:0]           upd_idx,
    input  logic [KEY_W-1:0]           upd_key,
    input  logic [RES_W-1:0]           upd_res,
    input  logic                       upd_vld,
    input  logic                       commit_req,
    input  logic                       retire_ack,
    output logic                       lkp_valid,
    output logic                       lkp_hit,
    output logic [RES_W-1:0]           lkp_res,
    output logic [VER_W-1:0]           lkp_ver,
    output logic                       active_bank,
    output logic [VER_W-1:0]           cur_ver,
    output logic                       retire_pending,
    output logic                       busy,
    output logic                       upd_err,
    output logic [NUM_BANKS*CNT_W-1:0] hit_count,
    output logic [NUM_BANKS*CNT_W-1:0] miss_count,
    output logic [NUM_BANKS*VER_W-1:0] bank_ver
);
    typedef struct packed {
        logic                            lv;
        logic                            lh;
        logic [RES_W-1:0]                lr;
        logic [VER_W-1:0]                lver;
        logic [NUM_BANKS-1:0][CNT_W-1:0] hc;
        logic [NUM_BANKS-1:0][CNT_W-1:0] mc;
        logic [NUM_BANKS-1:0][VER_W-1:0] bv;
    } dp_t;

    dp_t              dp_d, dp_q;
    logic             act, pend, accept;
    logic [VER_W-1:0] ver;
    logic [NUM_BANKS-1:0] b_hit;
    logic [RES_W-1:0]     b_res [NUM_BANKS];
    logic                 sel_hit;
    logic [RES_W-1:0]     sel_res;

    shb_ctrl #(.VER_W(VER_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_req (commit_req),
        .retire_ack (retire_ack),
        .upd_we     (upd_we),
        .active     (act),
        .version    (ver),
        .pending    (pend),
        .busy       (busy),
        .upd_err    (upd_err),
        .accept     (accept)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bank_we;
        assign bank_we = upd_we && !pend && (act != b[0]);
        shb_bank #(.KEY_W(KEY_W), .RES_W(RES_W), .DEPTH(DEPTH)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we),
            .widx  (upd_idx),
            .wkey  (upd_key),
            .wres  (upd_res),
            .wvld  (upd_vld),
            .qkey  (lkp_key),
            .qhit  (b_hit[b]),
            .qres  (b_res[b])
        );
    end

    assign sel_hit = b_hit[act];
    assign sel_res = b_res[act];

    always_comb begin
        dp_d      = dp_q;
        dp_d.lv   = lkp_req;
        dp_d.lh   = lkp_req && sel_hit;
        dp_d.lr   = (lkp_req && sel_hit) ? sel_res : '0;
        dp_d.lver = ver;
        if (lkp_req) begin
            if (sel_hit) begin
                if (dp_q.hc[act] != '1) dp_d.hc[act] = dp_q.hc[act] + 1'b1;
            end else begin
                if (dp_q.mc[act] != '1) dp_d.mc[act] = dp_q.mc[act] + 1'b1;
            end
        end
        if (accept) begin
            dp_d.hc[~act] = '0;
            dp_d.mc[~act] = '0;
            dp_d.bv[~act] = ver + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign lkp_valid      = dp_q.lv;
    assign lkp_hit        = dp_q.lh;
    assign lkp_res        = dp_q.lr;
    assign lkp_ver        = dp_q.lver;
    assign active_bank    = act;
    assign cur_ver        = ver;
    assign retire_pending = pend;
    assign hit_count      = dp_q.hc;
    assign miss_count     = dp_q.mc;
    assign bank_ver       = dp_q.bv;

    assert_lookup_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req |=> lkp_valid && (lkp_ver == $past(cur_ver)));
    assert_refused_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_we && retire_pending) |=> upd_err);
    assert_refused_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && retire_pending && !retire_ack) |=> busy && $stable(active_bank) && $stable(cur_ver));
    assert_miss_is_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_hit |-> (lkp_res == '0));
endmodule

// File: tb/shb_table_tb.sv
module shb_table_tb;
    localparam int KW = 4, RW = 8, DP = 4, CW = 4, VW = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, lkp_req, upd_we, upd_vld, commit_req, retire_ack;
    logic [KW-1:0] lkp_key, upd_key;
    logic [1:0] upd_idx;
    logic [RW-1:0] upd_res;
    logic lkp_valid, lkp_hit, active_bank, retire_pending, busy, upd_err;
    logic [RW-1:0] lkp_res;
    logic [VW-1:0] lkp_ver, cur_ver;
    logic [2*CW-1:0] hit_count, miss_count;
    logic [2*VW-1:0] bank_ver;

    shb_table #(.KEY_W(KW), .RES_W(RW), .DEPTH(DP), .CNT_W(CW), .VER_W(VW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lkp_req(lkp_req), .lkp_key(lkp_key),
        .upd_we(upd_we), .upd_idx(upd_idx), .upd_key(upd_key), .upd_res(upd_res),
        .upd_vld(upd_vld), .commit_req(commit_req), .retire_ack(retire_ack),
        .lkp_valid(lkp_valid), .lkp_hit(lkp_hit), .lkp_res(lkp_res), .lkp_ver(lkp_ver),
        .active_bank(active_bank), .cur_ver(cur_ver), .retire_pending(retire_pending),
        .busy(busy), .upd_err(upd_err), .hit_count(hit_count), .miss_count(miss_count),
        .bank_ver(bank_ver)
    );

    int total = 0, bad = 0;

    // bench model
    logic [KW-1:0] mk [2][DP];
    logic [RW-1:0] mr [2][DP];
    logic          mv [2][DP];
    logic m_act, m_pend, m_busy;
    logic [VW-1:0] m_ver;
    int m_hc [2], m_mc [2], m_bv [2];

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input logic lr, input logic [KW-1:0] lk,
                       input logic we, input logic [1:0] wi, input logic [KW-1:0] wk,
                       input logic [RW-1:0] wr, input logic wv,
                       input logic cm, input logic ak, input string tag);
        logic e_hit, e_err;
        logic [RW-1:0] e_res;
        logic [VW-1:0] e_ver;
        logic o_act, o_pend;
        lkp_req = lr; lkp_key = lk; upd_we = we; upd_idx = wi; upd_key = wk;
        upd_res = wr; upd_vld = wv; commit_req = cm; retire_ack = ak;
        o_act = m_act; o_pend = m_pend;
        e_hit = 1'b0; e_res = '0; e_ver = m_ver;
        for (int i = DP - 1; i >= 0; i--)
            if (mv[o_act][i] && mk[o_act][i] == lk) begin e_hit = 1'b1; e_res = mr[o_act][i]; end
        if (lr) begin
            if (e_hit) m_hc[o_act] = (m_hc[o_act] == 15) ? 15 : m_hc[o_act] + 1;
            else       m_mc[o_act] = (m_mc[o_act] == 15) ? 15 : m_mc[o_act] + 1;
        end
        e_err = we && o_pend;
        if (we && !o_pend) begin
            mk[!o_act][wi] = wk; mr[!o_act][wi] = wr; mv[!o_act][wi] = wv;
        end
        if (cm && !o_pend) begin
            m_act = !o_act; m_ver = m_ver + 1'b1; m_pend = 1'b1;
            m_hc[!o_act] = 0; m_mc[!o_act] = 0; m_bv[!o_act] = int'(m_ver);
        end
        if (ak && o_pend) m_pend = 1'b0;
        if (ak) m_busy = 1'b0;
        else if (cm && o_pend) m_busy = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (lr) begin
            chk(tag, "lkp_valid", lkp_valid, 1);
            chk(tag, "lkp_hit", lkp_hit, e_hit);
            chk(tag, "lkp_res", lkp_res, e_res);
            chk(tag, "lkp_ver", lkp_ver, e_ver);
        end
        chk(tag, "upd_err", upd_err, e_err);
        chk(tag, "active_bank", active_bank, m_act);
        chk(tag, "cur_ver", cur_ver, m_ver);
        chk(tag, "retire_pending", retire_pending, m_pend);
        chk(tag, "busy", busy, m_busy);
        for (int b = 0; b < 2; b++) begin
            chk(tag, "hit_count", hit_count[b*CW +: CW], m_hc[b]);
            chk(tag, "miss_count", miss_count[b*CW +: CW], m_mc[b]);
            chk(tag, "bank_ver", bank_ver[b*VW +: VW], m_bv[b]);
        end
        lkp_req = 0; upd_we = 0; commit_req = 0; retire_ack = 0;
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < 16; k++) cyc(1, 4'(k), 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input logic [1:0] i, input logic [KW-1:0] k, input logic [RW-1:0] r,
                      input logic v, input string tag);
        cyc(1, k, 1, i, k, r, v, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 0; lkp_req = 0; lkp_key = 0; upd_we = 0; upd_idx = 0; upd_key = 0;
        upd_res = 0; upd_vld = 0; commit_req = 0; retire_ack = 0;
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < DP; i++) begin mk[b][i] = 0; mr[b][i] = 0; mv[b][i] = 0; end
            m_hc[b] = 0; m_mc[b] = 0; m_bv[b] = 0;
        end
        m_act = 0; m_pend = 0; m_busy = 0; m_ver = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state at the ports
        chk("R1", "active_bank", active_bank, 0);
        chk("R1", "cur_ver", cur_ver, 0);
        chk("R1", "retire_pending", retire_pending, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "upd_err", upd_err, 0);
        chk("R1", "hit_count", hit_count, 0);
        chk("R1", "miss_count", miss_count, 0);
        chk("R1", "bank_ver", bank_ver, 0);
        sweep("R1");
        // R3 stage into bank 1 while lookups stay on bank 0
        wr(0, 4'd3, 8'hA1, 1, "R3");
        wr(1, 4'd7, 8'hB2, 1, "R3");
        wr(2, 4'd3, 8'hC3, 1, "R3");
        wr(3, 4'd9, 8'hD4, 0, "R3");
        sweep("R3");
        // R4 commit with a lookup in the same cycle
        cyc(1, 4'd3, 0, 0, 0, 0, 0, 1, 0, "R4");
        cyc(1, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R4");
        sweep("R2");
        // R5 refused writes while retired bank awaits acknowledgement
        wr(0, 4'd5, 8'hEE, 1, "R5");
        wr(1, 4'd6, 8'hEF, 1, "R5");
        // R6 refused commit
        cyc(1, 4'd7, 0, 0, 0, 0, 0, 1, 0, "R6");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R6");
        // R7 acknowledge, then a spare acknowledgement
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
        cyc(1, 4'd7, 0, 0, 0, 0, 0, 0, 1, "R7");
        // R7 refused commit together with ack after a fresh commit
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R4");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, "R7");
        sweep("R7");
        // bank 1 staging again, keeps old entries; R9 invalidate key 7
        wr(1, 4'd7, 8'h00, 0, "R9");
        wr(3, 4'd12, 8'h5C, 1, "R3");
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, "R4");
        sweep("R9");
        // R8 saturation of the miss counter
        for (int n = 0; n < 20; n++) cyc(1, 4'd15, 0, 0, 0, 0, 0, 0, 0, "R8");
        for (int n = 0; n < 18; n++) cyc(1, 4'd3, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R8 version wrap over many cutovers
        for (int r = 0; r < 10; r++) begin
            cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
            cyc(1, 4'd3, 0, 0, 0, 0, 0, 1, 0, "R4");
            cyc(1, 4'd12, 0, 0, 0, 0, 0, 0, 0, "R8");
        end
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7");
        wr(0, 4'd3, 8'h77, 1, "R3");
        cyc(1, 4'd3, 0, 0, 0, 0, 0, 1, 0, "R4");
        sweep("R2");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule